// File: doc/BRIEF.md
# Software-Filled Page Translation Cache

This block translates 32-bit virtual addresses into physical addresses with a 4 KB page. Every address inside one virtual page maps to the same physical page. The upper 20 bits of the virtual address form the virtual page number. The lower 12 bits pass through unchanged as the page offset. Translations live in a fully associative array of entries, 128 by default, which covers 512 KB of mapped memory. A lookup compares the page number against every entry in parallel. On a hit the block returns the stored physical page number joined with the original offset. On a miss it raises a miss exception flag and produces no translation.

The block never fetches mappings by itself; there is no table walker. Software handles each miss and installs the mapping through a write port that names an entry slot, a virtual page and a physical page. A single global invalidate input empties the whole array in one cycle. Lookup results are registered and appear one cycle after the request. Software must never hold two valid entries with the same virtual page number.

Top module: `sl_tlb`

## Requirements
- R1: After reset, and again whenever reset is asserted, every entry is invalid and `rsp_done`, `rsp_hit`, `rsp_miss` and `rsp_paddr` read 0.
- R2: The virtual page number is `lk_vaddr[31:12]` and the page offset is `lk_vaddr[11:0]`. Lookups that differ only in offset bits give the same hit or miss outcome and the same physical page.
- R3: A request with `lk_req` high whose page number matches a valid entry gives, one cycle later, `rsp_done`=1, `rsp_hit`=1, `rsp_miss`=0 and `rsp_paddr` = {stored physical page, `lk_vaddr[11:0]`}.
- R4: A request that matches no valid entry gives, one cycle later, `rsp_done`=1, `rsp_hit`=0, `rsp_miss`=1 and `rsp_paddr`=0.
- R5: In a cycle with `lk_req` low, the next cycle shows `rsp_done`, `rsp_hit`, `rsp_miss` and `rsp_paddr` all 0.
- R6: A cycle with `wr_en` high overwrites entry `wr_idx` with `wr_vpn`/`wr_ppn` and marks it valid. From then on the old page number of that slot misses and the new one hits with the new physical page.
- R7: A cycle with `inv_all` high and `wr_en` low makes every entry invalid, so that all later lookups miss until new writes are made.
- R8: When `inv_all` and `wr_en` are high in the same cycle, the written entry ends valid with its new mapping and every other entry ends invalid.
- R9: A lookup issued in the same cycle as a write or an invalidate is judged against the array contents from before that cycle's clock edge.
- R10: Every slot index from 0 to 127 can be written and hit on its own, including the highest index 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_done | output | 1 | Registered: a lookup completed last cycle |
| rsp_hit | output | 1 | Registered: the lookup found a mapping |
| rsp_miss | output | 1 | Registered: miss exception for the lookup |
| rsp_paddr | output | 32 | Registered translated physical address, 0 unless hit |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 7 | Slot index to overwrite |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_ppn | input | 20 | Physical page number to install |
| inv_all | input | 1 | Clear every valid bit |

## Verification
Two things can happen in one cycle: a lookup and an array update, and a software write and a global invalidate. The bench places a lookup in the same cycle as a write into the slot it probes. It also places one in the same cycle as an invalidate, and it expects each result from the array contents held before that edge. It then raises write and invalidate together. It judges the outcome by probing the written page, which must hit, and the pages of the other slots, which must miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_HIT  = 2'd1,
    RES_MISS = 2'd2
  } tlb_res_e;

  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned IDX_W = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [VPN_W-1:0]             wr_vpn,
  input  logic [PPN_W-1:0]             wr_ppn,
  input  logic                         inv_all,
  output logic [DEPTH-1:0]             valid_o,
  output logic [DEPTH-1:0][VPN_W-1:0]  vpn_o,
  output logic [DEPTH-1:0][PPN_W-1:0]  ppn_o
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic pick;
    assign pick = wr_en && (wr_idx == IDX_W'(e));

    // a write to this slot outranks the global clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_o[e] <= 1'b0;
      else if (pick)    valid_o[e] <= 1'b1;
      else if (inv_all) valid_o[e] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (pick) begin
        vpn_o[e] <= wr_vpn;
        ppn_o[e] <= wr_ppn;
      end
    end
  end

endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned VPN_W = 20
) (
  input  logic [VPN_W-1:0]             key_vpn,
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [DEPTH-1:0][VPN_W-1:0]  vpn_i,
  output logic [DEPTH-1:0]             match_o
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign match_o[e] = valid_i[e] && (vpn_i[e] == key_vpn);
  end

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned PPN_W = 20
) (
  input  logic [DEPTH-1:0]             match_i,
  input  logic [DEPTH-1:0][PPN_W-1:0]  ppn_i,
  output logic                         any_o,
  output logic [PPN_W-1:0]             ppn_o
);

  // AND-OR mux: correct because at most one match bit is set
  always_comb begin
    ppn_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      ppn_o = ppn_o | ({PPN_W{match_i[e]}} & ppn_i[e]);
    end
  end

  assign any_o = |match_i;

endmodule

// File: rtl/sl_tlb.sv
module sl_tlb #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned VPN_W = VA_W - PAGE_W,
  localparam int unsigned PPN_W = PA_W - PAGE_W,
  localparam int unsigned IDX_W = tlb_pkg::idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              rsp_done,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              inv_all
);
  import tlb_pkg::*;

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_W];
  endfunction

  function automatic logic [PAGE_W-1:0] offset_of(input logic [VA_W-1:0] va);
    return va[PAGE_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] pp,
                                              input logic [PAGE_W-1:0] off);
    return {pp, off};
  endfunction

  // named internal events for the checker
  logic [DEPTH-1:0]             valid_vec;
  logic [DEPTH-1:0][VPN_W-1:0]  vpn_arr;
  logic [DEPTH-1:0][PPN_W-1:0]  ppn_arr;
  logic [DEPTH-1:0]             match_vec;
  logic                         any_hit;
  logic [PPN_W-1:0]             hit_ppn;

  tlb_entry_store #(
    .DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_vpn  (wr_vpn),
    .wr_ppn  (wr_ppn),
    .inv_all (inv_all),
    .valid_o (valid_vec),
    .vpn_o   (vpn_arr),
    .ppn_o   (ppn_arr)
  );

  tlb_match_array #(.DEPTH(DEPTH), .VPN_W(VPN_W)) cam_i (
    .key_vpn (page_of(lk_vaddr)),
    .valid_i (valid_vec),
    .vpn_i   (vpn_arr),
    .match_o (match_vec)
  );

  tlb_hit_select #(.DEPTH(DEPTH), .PPN_W(PPN_W)) sel_i (
    .match_i (match_vec),
    .ppn_i   (ppn_arr),
    .any_o   (any_hit),
    .ppn_o   (hit_ppn)
  );

  tlb_res_e          res_q;
  logic [PA_W-1:0]   pa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_NONE;
      pa_q  <= '0;
    end else if (lk_req) begin
      res_q <= any_hit ? RES_HIT : RES_MISS;
      pa_q  <= any_hit ? join_pa(hit_ppn, offset_of(lk_vaddr)) : '0;
    end else begin
      res_q <= RES_NONE;
      pa_q  <= '0;
    end
  end

  assign rsp_done  = (res_q != RES_NONE);
  assign rsp_hit   = (res_q == RES_HIT);
  assign rsp_miss  = (res_q == RES_MISS);
  assign rsp_paddr = pa_q;

endmodule

// File: rtl/sl_tlb_chk.sv
module sl_tlb_chk #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned IDX_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic              rsp_done,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              inv_all,
  input logic [DEPTH-1:0]  valid_vec,
  input logic [DEPTH-1:0]  match_vec
);

  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r4_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));

  a_r3_request_answered: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_done && (rsp_hit != rsp_miss));

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_miss || (rsp_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0])));

  a_r4_miss_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_paddr == '0);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_done && !rsp_hit && !rsp_miss && rsp_paddr == '0);

  a_r6_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_vec[$past(wr_idx)]);

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !wr_en |=> valid_vec == '0);

  a_r8_clear_keeps_written: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && wr_en |=> $countones(valid_vec) == 1);

endmodule

bind sl_tlb sl_tlb_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .lk_vaddr  (lk_vaddr),
  .rsp_done  (rsp_done),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_paddr (rsp_paddr),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .inv_all   (inv_all),
  .valid_vec (valid_vec),
  .match_vec (match_vec)
);

// File: tb/sl_tlb_tb_top.sv
module sl_tlb_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        rsp_done, rsp_hit, rsp_miss;
  logic [31:0] rsp_paddr;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0;
  logic [19:0] wr_ppn = '0;
  logic        inv_all = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench-side reference of the table
  bit          ref_v   [SLOTS];
  logic [19:0] ref_vpn [SLOTS];
  logic [19:0] ref_ppn [SLOTS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sl_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .rsp_done(rsp_done), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_paddr(rsp_paddr), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .inv_all(inv_all)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic ref_clear();
    for (int i = 0; i < SLOTS; i++) ref_v[i] = 1'b0;
  endtask

  // expected translation computed from the reference: page = va>>12
  task automatic ref_look(input logic [31:0] va, output bit hit, output logic [31:0] pa);
    hit = 1'b0;
    pa  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (ref_v[i] && ref_vpn[i] == va[31:12]) begin
        hit = 1'b1;
        pa  = {ref_ppn[i], va[11:0]};
      end
    end
  endtask

  task automatic check_result(input string req, input bit hit, input logic [31:0] pa);
    chk(req, "done", {31'b0, rsp_done}, 32'd1);
    chk(req, "hit",  {31'b0, rsp_hit},  {31'b0, hit});
    chk(req, "miss", {31'b0, rsp_miss}, {31'b0, !hit});
    chk(req, "paddr", rsp_paddr, pa);
  endtask

  task automatic install(input int idx, input logic [19:0] vp, input logic [19:0] pp);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 7'(idx); wr_vpn = vp; wr_ppn = pp;
    @(negedge clk);
    wr_en = 1'b0;
    ref_v[idx] = 1'b1; ref_vpn[idx] = vp; ref_ppn[idx] = pp;
  endtask

  task automatic probe(input string req, input logic [31:0] va);
    bit hit; logic [31:0] pa;
    ref_look(va, hit, pa);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_req = 1'b0;
    check_result(req, hit, pa);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ref_clear();
    repeat (3) @(negedge clk);
    chk("R1", "done at reset", {31'b0, rsp_done}, 32'd0);
    chk("R1", "miss at reset", {31'b0, rsp_miss}, 32'd0);
    chk("R1", "paddr at reset", rsp_paddr, 32'd0);
    rst_n = 1'b1;
    probe("R1", 32'h1234_5678);
  endtask

  task automatic t_hit_and_miss();
    install(0, 20'h12345, 20'hABCDE);
    install(5, 20'h00001, 20'h00777);
    probe("R3", 32'h1234_5ABC);
    probe("R3", 32'h0000_1004);
    probe("R4", 32'h0000_2004);
    probe("R4", 32'hDEAD_B000);
  endtask

  task automatic t_offsets();
    probe("R2", 32'h1234_5000);
    probe("R2", 32'h1234_5FFF);
    probe("R2", 32'h1234_5801);
    probe("R2", 32'h1234_6000);
  endtask

  task automatic t_idle();
    probe("R5", 32'h1234_5111);
    @(negedge clk);
    chk("R5", "done idle", {31'b0, rsp_done}, 32'd0);
    chk("R5", "hit idle", {31'b0, rsp_hit}, 32'd0);
    chk("R5", "paddr idle", rsp_paddr, 32'd0);
  endtask

  task automatic t_overwrite();
    install(5, 20'h22222, 20'h33333);
    probe("R6", 32'h0000_1004);
    probe("R6", 32'h2222_2ABC);
  endtask

  task automatic t_last_slot();
    install(127, 20'hFFFFF, 20'h00042);
    probe("R10", 32'hFFFF_F123);
    for (int i = 10; i < 20; i++) install(i, 20'h40000 + 20'(i), 20'h50000 + 20'(i));
    for (int i = 10; i < 20; i++) probe("R10", {12'h400, 8'(i), 12'h0A5});
  endtask

  task automatic t_invalidate();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    ref_clear();
    probe("R7", 32'h1234_5ABC);
    probe("R7", 32'hFFFF_F000);
    probe("R7", 32'h4000_A0A5);
  endtask

  task automatic t_inv_with_write();
    install(3, 20'h0AAAA, 20'h01111);
    install(4, 20'h0BBBB, 20'h02222);
    @(negedge clk);
    inv_all = 1'b1; wr_en = 1'b1; wr_idx = 7'd9; wr_vpn = 20'h0CCCC; wr_ppn = 20'h03333;
    @(negedge clk);
    inv_all = 1'b0; wr_en = 1'b0;
    ref_clear();
    ref_v[9] = 1'b1; ref_vpn[9] = 20'h0CCCC; ref_ppn[9] = 20'h03333;
    probe("R8", 32'h0CCC_C010);
    probe("R8", 32'h0AAA_A010);
    probe("R8", 32'h0BBB_B010);
  endtask

  task automatic t_collide();
    bit hit; logic [31:0] pa;
    // lookup in the same cycle as a write into the slot it targets: old view
    ref_look(32'h0DDD_D200, hit, pa);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = 32'h0DDD_D200;
    wr_en = 1'b1; wr_idx = 7'd9; wr_vpn = 20'h0DDDD; wr_ppn = 20'h04444;
    @(negedge clk);
    lk_req = 1'b0; wr_en = 1'b0;
    check_result("R9", hit, pa);
    ref_v[9] = 1'b1; ref_vpn[9] = 20'h0DDDD; ref_ppn[9] = 20'h04444;
    probe("R9", 32'h0DDD_D200);
    // lookup in the same cycle as a global clear: still sees the entry
    ref_look(32'h0DDD_D3FF, hit, pa);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = 32'h0DDD_D3FF; inv_all = 1'b1;
    @(negedge clk);
    lk_req = 1'b0; inv_all = 1'b0;
    check_result("R9", hit, pa);
    ref_clear();
    probe("R9", 32'h0DDD_D3FF);
  endtask

  task automatic t_reset_mid();
    install(1, 20'h07777, 20'h08888);
    probe("R1", 32'h0777_7000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ref_clear();
    probe("R1", 32'h0777_7000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hit_and_miss();
    t_offsets();
    t_idle();
    t_overwrite();
    t_last_slot();
    t_invalidate();
    t_inv_with_write();
    t_collide();
    t_reset_mid();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule